// File: doc/BRIEF.md
# Open-Drain Line Repeater Core

This block joins two segments of one open-drain wire, called side A and side B, so that a LOW pulled by any device on either segment appears on the other. It never drives the wire itself. It reads digital LOW-sense flags for each segment and produces two pull-down enables, one per side, for pad drivers outside the block. A serial bus needs one instance for its data line and one for its clock line.

Side B has two sense inputs. The loose LOW flag trips at a level that the block's own side-B offset pull-down also reaches. The contention LOW flag trips only when an external device pulls harder than that offset. A LOW that the block echoes onto side B therefore never comes back to side A, so the two directions cannot hold each other LOW. When a LOW that started on side B ends, side A is released first, and side B's pull-down stays on until side A reads HIGH again. On side B this shows as a short plateau. The repeater drives nothing while the link-enable input is low. After enable rises, it waits until both segments read HIGH before it joins them.

All three sense inputs pass through a two-flop synchronizer. A state machine records which side started the current LOW. Its states are:
- OFF: disconnected.
- IDLE: joined, nothing driven.
- A_OWN: side A started the LOW; B is driven.
- B_FIRST: side B started the LOW; A is driven.
- B_HOLD: both sides driven.
- PLATEAU: only B is driven, waiting for side A to read HIGH.
- SETTLE: nothing driven, waiting for both sides to read HIGH.

The transitions are:
- OFF to IDLE when enabled and both sides read HIGH.
- IDLE to A_OWN on an A LOW. A has priority over B.
- IDLE to B_FIRST on a loose B LOW.
- A_OWN to B_FIRST when A reads HIGH while a contention LOW is present on B.
- A_OWN to SETTLE when A reads HIGH with no contention LOW on B.
- B_FIRST to B_HOLD when A reads LOW.
- B_FIRST to SETTLE when the loose B LOW ends.
- B_HOLD to PLATEAU when the contention LOW ends.
- PLATEAU to SETTLE when A reads HIGH.
- SETTLE to B_FIRST on a contention LOW.
- SETTLE to A_OWN on an A LOW.
- SETTLE to IDLE when both sides read HIGH.
- Any state to OFF when enable is low.

Top module: `od_line_repeater`

## Requirements
- R1: After reset both pull-down outputs are 0.
- R2: A LOW on side A (`a_low_i`=1) turns on `b_pull_o` and leaves `a_pull_o` at 0. The turn-on comes exactly three rising clock edges after the input changes: two synchronizer flops and the state register.
- R3: While the block drives side B for an A-side LOW, the resulting loose B LOW (`b_low_i`=1) never turns on `a_pull_o`. Once side A is released, both outputs return to 0 and stay there.
- R4: A contention LOW on side B (`b_hard_low_i`=1 with `b_low_i`=1) turns on `a_pull_o`. Once side A reads LOW, `b_pull_o` also turns on.
- R5: When the contention LOW ends, `a_pull_o` turns off first and `b_pull_o` stays on. `b_pull_o` turns off only after side A reads HIGH.
- R6: If side B goes LOW only at the loose level, `a_pull_o` pulses for exactly four cycles and then stays off while the weak LOW persists.
- R7: When side A is released while side B holds a contention LOW, `a_pull_o` turns on, which passes clock stretching and arbitration across. A loose-only B LOW at that moment does not turn on `a_pull_o`.
- R8: While `link_en_i` is 0, both outputs are 0 in that same cycle, even in the middle of a transfer.
- R9: After `link_en_i` rises, the block joins the segments only once both sides read HIGH.
- R10: `b_pull_o` turns off only in a cycle whose synchronized side-A sense read HIGH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_en_i | input | 1 | 1 = repeater may join the two segments |
| a_low_i | input | 1 | Side A sensed LOW |
| b_low_i | input | 1 | Side B sensed LOW at the loose (first-LOW) level |
| b_hard_low_i | input | 1 | Side B sensed LOW at the strict contention level |
| a_pull_o | output | 1 | Enable for the side-A hard pull-down |
| b_pull_o | output | 1 | Enable for the side-B offset pull-down |

## Verification
The bench closes the loop: each pull-down output is ORed back into its own segment's sense inputs, as a real wire would do, while external drivers pull each side. An A-originated LOW checks the latency and shows that the block's own echo on B does not latch A. A strong B LOW brings out the plateau ordering, and a weak B LOW brings out the bounded glitch on A, so the two B sense levels are told apart. An A release over a strong or a weak B LOW separates stretching that passes across from echo that is ignored. Dropping and raising enable under an active bus shows both the immediate release and the wait for idle before the segments are joined again.

// File: rtl/rptr_pkg.sv
package rptr_pkg;

    typedef enum logic [2:0] {
        ST_OFF,      // link disabled, nothing driven
        ST_IDLE,     // joined, both segments HIGH
        ST_A_OWN,    // LOW started on side A, driving side B
        ST_B_FIRST,  // LOW started on side B, driving side A
        ST_B_HOLD,   // side-B originated, driving both sides
        ST_PLATEAU,  // side A released, holding B until A reads HIGH
        ST_SETTLE    // nothing driven, waiting for both sides HIGH
    } rptr_state_e;

    localparam int SENSE_W = 3;
    localparam int IDX_A   = 0;
    localparam int IDX_B   = 1;
    localparam int IDX_BH  = 2;

endpackage

// File: rtl/rptr_sync.sv
module rptr_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= '0;
                    else        pipe[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= '0;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe[LAST];

endmodule

// File: rtl/rptr_fsm.sv
module rptr_fsm
    import rptr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic link_en,
    input  logic a_lo,
    input  logic b_lo,
    input  logic b_hard,
    output logic drv_a,
    output logic drv_b
);

    rptr_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!link_en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:     if (!a_lo && !b_lo) state_d = ST_IDLE;
                ST_IDLE: begin
                    if (a_lo)      state_d = ST_A_OWN;
                    else if (b_lo) state_d = ST_B_FIRST;
                end
                ST_A_OWN: begin
                    // own echo on B is ignored; only a hard LOW crosses back
                    if (!a_lo) state_d = b_hard ? ST_B_FIRST : ST_SETTLE;
                end
                ST_B_FIRST: begin
                    if (a_lo)       state_d = ST_B_HOLD;
                    else if (!b_lo) state_d = ST_SETTLE;
                end
                ST_B_HOLD:  if (!b_hard) state_d = ST_PLATEAU;
                ST_PLATEAU: if (!a_lo)   state_d = ST_SETTLE;
                ST_SETTLE: begin
                    if (b_hard)              state_d = ST_B_FIRST;
                    else if (a_lo)           state_d = ST_A_OWN;
                    else if (!b_lo)          state_d = ST_IDLE;
                end
                default:                     state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        drv_a = 1'b0;
        drv_b = 1'b0;
        unique case (state_q)
            ST_OFF, ST_IDLE, ST_SETTLE: ;
            ST_A_OWN:   drv_b = 1'b1;
            ST_B_FIRST: drv_a = 1'b1;
            ST_B_HOLD: begin
                drv_a = 1'b1;
                drv_b = 1'b1;
            end
            ST_PLATEAU: drv_b = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/rptr_gate.sv
module rptr_gate #(
    parameter int LANES = 2
) (
    input  logic             en,
    input  logic [LANES-1:0] req,
    output logic [LANES-1:0] drive
);

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign drive[i] = req[i] & en;
        end
    endgenerate

endmodule

// File: rtl/od_line_repeater.sv
module od_line_repeater
    import rptr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_en_i,
    input  logic a_low_i,
    input  logic b_low_i,
    input  logic b_hard_low_i,
    output logic a_pull_o,
    output logic b_pull_o
);

    logic [SENSE_W-1:0] sense_raw;
    logic [SENSE_W-1:0] sense_q;
    logic               a_seen;
    logic               drv_a_req;
    logic               drv_b_req;
    logic [1:0]         drive;

    assign sense_raw[IDX_A]  = a_low_i;
    assign sense_raw[IDX_B]  = b_low_i;
    assign sense_raw[IDX_BH] = b_hard_low_i;

    rptr_sync #(.WIDTH(SENSE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sense_raw),
        .q_o   (sense_q)
    );

    assign a_seen = sense_q[IDX_A];

    rptr_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_en (link_en_i),
        .a_lo    (a_seen),
        .b_lo    (sense_q[IDX_B]),
        .b_hard  (sense_q[IDX_BH]),
        .drv_a   (drv_a_req),
        .drv_b   (drv_b_req)
    );

    rptr_gate #(.LANES(2)) u_gate (
        .en    (link_en_i),
        .req   ({drv_b_req, drv_a_req}),
        .drive (drive)
    );

    assign a_pull_o = drive[0];
    assign b_pull_o = drive[1];

endmodule

// File: rtl/od_line_repeater_chk.sv
module od_line_repeater_chk (
    input logic clk,
    input logic rst_n,
    input logic link_en_i,
    input logic a_seen,
    input logic a_pull_o,
    input logic b_pull_o
);

    assert_off_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en_i |-> (!a_pull_o && !b_pull_o));

    assert_no_echo_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_pull_o) |-> !b_pull_o);

    assert_plateau_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(a_pull_o) && $past(b_pull_o) && link_en_i && $past(link_en_i)) |-> b_pull_o);

    assert_b_release_on_a_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(b_pull_o) && link_en_i && $past(link_en_i)) |-> !$past(a_seen));

    assert_a_low_drives_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(b_pull_o) && !a_pull_o) |-> $past(a_seen));

endmodule

bind od_line_repeater od_line_repeater_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_en_i (link_en_i),
    .a_seen    (a_seen),
    .a_pull_o  (a_pull_o),
    .b_pull_o  (b_pull_o)
);

// File: tb/od_line_repeater_bench.sv
module od_line_repeater_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_en = 1'b1;
    logic ext_a = 1'b0;
    logic ext_bw = 1'b0;
    logic ext_bs = 1'b0;
    logic a_pull, b_pull;
    logic a_lo, b_lo, b_hard;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    // closed-loop wire model: own pull-downs feed back into the sense flags
    assign a_lo   = ext_a | a_pull;
    assign b_lo   = ext_bw | ext_bs | b_pull;
    assign b_hard = ext_bs;

    od_line_repeater u_od_line_repeater (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_en_i    (link_en),
        .a_low_i      (a_lo),
        .b_low_i      (b_lo),
        .b_hard_low_i (b_hard),
        .a_pull_o     (a_pull),
        .b_pull_o     (b_pull)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", "a_pull after reset", a_pull, 1'b0);
        check("R1", "b_pull after reset", b_pull, 1'b0);
    endtask

    task automatic t_a_origin();
        ext_a = 1'b1;
        edges(2);
        check("R2", "b_pull before third edge", b_pull, 1'b0);
        edges(1);
        check("R2", "b_pull at third edge", b_pull, 1'b1);
        check("R2", "a_pull stays off", a_pull, 1'b0);
        edges(10);
        check("R3", "echo does not drive A", a_pull, 1'b0);
        ext_a = 1'b0;
        edges(12);
        check("R3", "a_pull after A release", a_pull, 1'b0);
        check("R3", "b_pull after A release", b_pull, 1'b0);
    endtask

    task automatic t_b_strong();
        ext_bs = 1'b1;
        edges(3);
        check("R4", "a_pull on hard B LOW", a_pull, 1'b1);
        check("R4", "b_pull before A reads LOW", b_pull, 1'b0);
        edges(7);
        check("R4", "b_pull once A LOW", b_pull, 1'b1);
        check("R4", "a_pull held", a_pull, 1'b1);
        ext_bs = 1'b0;
        edges(3);
        check("R5", "a_pull released first", a_pull, 1'b0);
        check("R5", "b_pull plateau", b_pull, 1'b1);
        edges(3);
        check("R5", "b_pull after A HIGH", b_pull, 1'b0);
        edges(10);
        check("R5", "idle a_pull", a_pull, 1'b0);
        check("R5", "idle b_pull", b_pull, 1'b0);
    endtask

    task automatic t_b_weak();
        int hi = 0;
        ext_bw = 1'b1;
        for (int i = 0; i < 30; i++) begin
            edges(1);
            if (a_pull) hi++;
        end
        n_chk++;
        if (hi != 4) begin
            n_bad++;
            $display("FAIL R6 glitch width: actual=%0d expected=%0d", hi, 4);
        end
        check("R6", "a_pull off under weak LOW", a_pull, 1'b0);
        check("R6", "b_pull off under weak LOW", b_pull, 1'b0);
        ext_bw = 1'b0;
        edges(10);
    endtask

    task automatic t_stretch();
        ext_a = 1'b1;
        edges(10);
        ext_bs = 1'b1;
        edges(5);
        check("R7", "a_pull while A held externally", a_pull, 1'b0);
        ext_a = 1'b0;
        edges(3);
        check("R7", "hard B LOW reaches A", a_pull, 1'b1);
        edges(10);
        check("R7", "b_pull after A follows", b_pull, 1'b1);
        ext_bs = 1'b0;
        edges(15);
        check("R7", "idle after stretch", a_pull | b_pull, 1'b0);
        // weak B over an A release must not cross
        ext_a = 1'b1;
        edges(10);
        ext_bw = 1'b1;
        ext_a = 1'b0;
        begin
            logic seen = 1'b0;
            for (int i = 0; i < 12; i++) begin
                edges(1);
                seen = seen | a_pull;
            end
            check("R7", "weak B LOW does not reach A", seen, 1'b0);
        end
        ext_bw = 1'b0;
        edges(10);
    endtask

    task automatic t_enable();
        ext_a = 1'b1;
        edges(6);
        check("R8", "b_pull before disable", b_pull, 1'b1);
        link_en = 1'b0;
        #1;
        check("R8", "b_pull same cycle disable", b_pull, 1'b0);
        edges(5);
        ext_bs = 1'b1;
        edges(6);
        check("R8", "a_pull while disabled", a_pull, 1'b0);
        ext_bs = 1'b0;
        link_en = 1'b1;
        edges(10);
        check("R9", "no join while A busy", b_pull, 1'b0);
        ext_a = 1'b0;
        edges(6);
        ext_a = 1'b1;
        edges(4);
        check("R9", "join after idle", b_pull, 1'b1);
        ext_a = 1'b0;
        edges(10);
        check("R10", "b_pull released after A HIGH", b_pull, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        edges(4);
        t_a_origin();
        t_b_strong();
        t_b_weak();
        t_stretch();
        t_enable();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule